// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block is one warp scheduler of a multiprocessor. It watches a pool of warps, each warp being a group of 32 threads that share one instruction stream. Every cycle it grants one eligible warp and sends that warp's next instruction to dispatch slot 0. When the instruction after it is marked independent and is ready too, it sends that one to slot 1 in the same cycle. Instruction decode and the execution units are outside this block. The instruction buffer sits in front of it and shows, for every warp, its first two waiting instructions. The instruction buffer pops whatever the scheduler granted at the clock edge that ends the grant cycle.

Eligibility needs no dependency checker. Each instruction carries a latency that the compiler fixed for it. On issue that latency is loaded into a per-warp countdown, and the warp is masked until the countdown reaches zero. Loads and texture fetches have variable latency, so they are tracked by a small per-warp scoreboard. An entry is set when such an instruction issues and cleared by a writeback notice. An instruction whose source register is pending cannot issue. Among the eligible warps, the one issued least recently wins.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst_n` is low nothing issues (`s0_vld`=`s1_vld`=0). After reset all countdowns are zero, all scoreboard entries are clear and no warp has issued yet.
- R2: Among the eligible warps, slot 0 takes the one whose last issue is oldest. Warps that have not issued since reset count as oldest of all, and ties go to the lowest warp index. A warp is eligible when `h0_vld` is set, its countdown is zero, and its head does not read a pending register.
- R3: After an issue with stall value L (0..15), that warp cannot issue in the next L cycles and can issue again in cycle L+1. With L=0 it may issue back to back.
- R4: Issuing an instruction with `*_long`=1 sets the entry (warp, `*_dst`). A head with `*_rd_en`=1 whose `*_rd` entry is pending cannot issue. Entries of other warps are unaffected.
- R5: A `wb_vld` pulse clears entry (`wb_warp`, `wb_reg`). The cleared register counts as ready from the following cycle, not in the writeback cycle.
- R6: Slot 1 issues only together with slot 0, and only when the granted warp has `h1_vld`=1 and `h1_indep`=1 and its second instruction does not read a pending register. `s1_warp` then equals `s0_warp`.
- R7: When a writeback and a long-latency issue target the same entry in one cycle, the entry is pending afterwards.
- R8: Double-precision flags never prevent pairing. `s0_dp`/`s1_dp` show the `dp` flag of the instruction issued in that slot, and are 0 when the slot is idle.
- R9: For a paired issue the stall value is the larger of the two latencies. For a single issue it is the slot-0 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h0_vld | input | NW | First waiting instruction present, per warp |
| h0_lat | input | NW×LW | Fixed latency of the first instruction |
| h0_long | input | NW | First instruction is a load or texture fetch |
| h0_dp | input | NW | First instruction is double precision |
| h0_dst | input | NW×log2(NR) | Tracked destination register of the first instruction |
| h0_rd_en | input | NW | First instruction reads a tracked register |
| h0_rd | input | NW×log2(NR) | Tracked source register of the first instruction |
| h1_vld | input | NW | Second instruction present |
| h1_indep | input | NW | Second instruction does not depend on the first |
| h1_lat | input | NW×LW | Fixed latency of the second instruction |
| h1_long | input | NW | Second instruction is a load or texture fetch |
| h1_dp | input | NW | Second instruction is double precision |
| h1_dst | input | NW×log2(NR) | Tracked destination of the second instruction |
| h1_rd_en | input | NW | Second instruction reads a tracked register |
| h1_rd | input | NW×log2(NR) | Tracked source of the second instruction |
| wb_vld | input | 1 | Long-latency result written back this cycle |
| wb_warp | input | log2(NW) | Warp of the writeback |
| wb_reg | input | log2(NR) | Register of the writeback |
| s0_vld | output | 1 | Slot 0 issues this cycle |
| s0_warp | output | log2(NW) | Warp issued in slot 0 |
| s0_dp | output | 1 | Slot-0 instruction is double precision |
| s1_vld | output | 1 | Slot 1 issues this cycle |
| s1_warp | output | log2(NW) | Warp issued in slot 1 |
| s1_dp | output | 1 | Slot-1 instruction is double precision |

## Verification
Two things can hit the same scoreboard entry in one cycle: a writeback clearing it and a load setting it. The bench forces this on purpose. It issues a load to a register while a writeback for that same warp and register arrives. It then shows that the next reader of that register is held back until a later, separate writeback. A random phase makes the same collision happen by chance, and a countdown expiring in the cycle a scoreboard entry clears also occurs there. Every cycle's grant is compared with a cycle model in the bench. That model keeps timestamps for issue order rather than an age matrix.

// File: rtl/wis_pkg.sv
// Package: shared defaults and helpers for the warp issue scheduler.
// Assumes latencies are unsigned and fit into 32 bits.
package wis_pkg;
    localparam int DEF_WARPS   = 16;
    localparam int DEF_LAT_W   = 4;
    localparam int DEF_SB_REGS = 8;

    // Stall value of a paired issue: the larger of the two latencies.
    function automatic int unsigned pair_stall(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/wis_warp_slot.sv
// Per-warp state: the latency countdown and the scoreboard row.
// Says whether the head instruction is eligible and whether the second
// instruction's source is ready. Assumes the set and clear masks are
// already decoded by the parent. When an entry is set and cleared in the
// same cycle, the set wins.
module wis_warp_slot #(
    parameter int LW = 4,
    parameter int NR = 8,
    localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [LW-1:0] new_lat,
    input  logic [NR-1:0] set_mask,
    input  logic [NR-1:0] clr_mask,
    input  logic          h0_vld,
    input  logic          h0_rd_en,
    input  logic [RW-1:0] h0_rd,
    input  logic          h1_rd_en,
    input  logic [RW-1:0] h1_rd,
    output logic          elig,
    output logic          h1_ok
);
    logic [LW-1:0] cnt_q;
    logic [NR-1:0] pend_q;

    // Countdown: load on issue, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (issue)
            cnt_q <= new_lat;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - LW'(1);
    end

    // Scoreboard row: clear writebacks first, then set new pending entries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_mask) | set_mask;
    end

    // Readiness of both waiting instructions, from registered state only.
    always_comb begin
        elig  = h0_vld && (cnt_q == '0) && !(h0_rd_en && pend_q[h0_rd]);
        h1_ok = !(h1_rd_en && pend_q[h1_rd]);
    end
endmodule

// File: rtl/wis_age_pick.sv
// Oldest-first arbiter built on an age matrix.
// older_q[i][j]=1 means warp i issued less recently than warp j. After
// reset the order follows the warp index, so before any issue the lowest
// index wins. A grant moves the winner to the youngest position.
module wis_age_pick #(
    parameter int NW = 16,
    localparam int WW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] elig,
    output logic          grant_vld,
    output logic [WW-1:0] grant_id
);
    logic [NW-1:0][NW-1:0] older_q;
    logic [NW-1:0]         win;

    // Winner: eligible and older than every other eligible warp.
    always_comb begin
        for (int w = 0; w < NW; w++) begin
            win[w] = elig[w];
            for (int j = 0; j < NW; j++)
                if (j != w && elig[j] && !older_q[w][j])
                    win[w] = 1'b0;
        end
    end

    // Encode the single winner.
    always_comb begin
        grant_id = '0;
        for (int w = 0; w < NW; w++)
            if (win[w]) grant_id = WW'(w);
        grant_vld = |win;
    end

    // Age update: the granted warp becomes the youngest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++)
                for (int j = 0; j < NW; j++)
                    older_q[i][j] <= (i < j);
        end else if (grant_vld) begin
            for (int j = 0; j < NW; j++)
                if (j != int'(grant_id)) begin
                    older_q[grant_id][j] <= 1'b0;
                    older_q[j][grant_id] <= 1'b1;
                end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
// Dual-issue warp scheduler top.
// Each cycle it grants the oldest eligible warp to slot 0 and, when
// allowed, that warp's next instruction to slot 1. The issue outputs are
// combinational from the instruction-buffer heads and registered state.
// Assumes the buffer pops the granted instructions at the clock edge that
// ends the grant cycle.
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NW = DEF_WARPS,
    parameter int LW = DEF_LAT_W,
    parameter int NR = DEF_SB_REGS,
    localparam int WW = (NW > 1) ? $clog2(NW) : 1,
    localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NW-1:0]          h0_vld,
    input  logic [NW-1:0][LW-1:0]  h0_lat,
    input  logic [NW-1:0]          h0_long,
    input  logic [NW-1:0]          h0_dp,
    input  logic [NW-1:0][RW-1:0]  h0_dst,
    input  logic [NW-1:0]          h0_rd_en,
    input  logic [NW-1:0][RW-1:0]  h0_rd,
    input  logic [NW-1:0]          h1_vld,
    input  logic [NW-1:0]          h1_indep,
    input  logic [NW-1:0][LW-1:0]  h1_lat,
    input  logic [NW-1:0]          h1_long,
    input  logic [NW-1:0]          h1_dp,
    input  logic [NW-1:0][RW-1:0]  h1_dst,
    input  logic [NW-1:0]          h1_rd_en,
    input  logic [NW-1:0][RW-1:0]  h1_rd,
    input  logic                   wb_vld,
    input  logic [WW-1:0]          wb_warp,
    input  logic [RW-1:0]          wb_reg,
    output logic                   s0_vld,
    output logic [WW-1:0]          s0_warp,
    output logic                   s0_dp,
    output logic                   s1_vld,
    output logic [WW-1:0]          s1_warp,
    output logic                   s1_dp
);
    logic [NW-1:0] elig;
    logic [NW-1:0] h1_ok;
    logic          grant_vld;
    logic [WW-1:0] gid;
    logic          iss0, iss1;
    logic [LW-1:0] stall_lat;
    logic [NR-1:0] set_row;
    logic [NR-1:0] clr_row;

    // Eligible warps are masked while reset is held.
    logic [NW-1:0] elig_gated;
    assign elig_gated = rst_n ? elig : '0;

    wis_age_pick #(.NW(NW)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig_gated),
        .grant_vld (grant_vld),
        .grant_id  (gid)
    );

    // Slot decisions and the stall value for the granted warp.
    always_comb begin
        iss0 = grant_vld;
        iss1 = grant_vld && h1_vld[gid] && h1_indep[gid] && h1_ok[gid];
        stall_lat = iss1 ? LW'(pair_stall(32'(h0_lat[gid]), 32'(h1_lat[gid])))
                         : h0_lat[gid];
    end

    // Scoreboard entries set by long-latency instructions of the granted warp.
    always_comb begin
        set_row = '0;
        if (iss0 && h0_long[gid]) set_row[h0_dst[gid]] = 1'b1;
        if (iss1 && h1_long[gid]) set_row[h1_dst[gid]] = 1'b1;
    end

    // Decoded writeback register, applied to the addressed warp only.
    always_comb begin
        clr_row = '0;
        clr_row[wb_reg] = wb_vld;
    end

    // One state slice per warp.
    for (genvar w = 0; w < NW; w++) begin : g_warp
        logic sel;
        assign sel = iss0 && (gid == WW'(w));
        wis_warp_slot #(.LW(LW), .NR(NR)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue    (sel),
            .new_lat  (stall_lat),
            .set_mask (sel ? set_row : '0),
            .clr_mask ((wb_warp == WW'(w)) ? clr_row : '0),
            .h0_vld   (h0_vld[w]),
            .h0_rd_en (h0_rd_en[w]),
            .h0_rd    (h0_rd[w]),
            .h1_rd_en (h1_rd_en[w]),
            .h1_rd    (h1_rd[w]),
            .elig     (elig[w]),
            .h1_ok    (h1_ok[w])
        );
    end

    // Issue outputs for both dispatch slots.
    always_comb begin
        s0_vld  = iss0;
        s0_warp = iss0 ? gid : '0;
        s0_dp   = iss0 && h0_dp[gid];
        s1_vld  = iss1;
        s1_warp = iss1 ? gid : '0;
        s1_dp   = iss1 && h1_dp[gid];
    end
endmodule

// File: rtl/wis_checker.sv
// Property checker for warp_issue_sched, attached by bind below.
// Watches ports only. Assumes reset is held low at the first clock edge.
module wis_checker #(
    parameter int NW = 16,
    parameter int LW = 4,
    parameter int NR = 8,
    localparam int WW = (NW > 1) ? $clog2(NW) : 1,
    localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NW-1:0]          h0_vld,
    input logic [NW-1:0][LW-1:0]  h0_lat,
    input logic [NW-1:0]          h0_long,
    input logic [NW-1:0][RW-1:0]  h0_dst,
    input logic [NW-1:0]          h0_rd_en,
    input logic [NW-1:0][RW-1:0]  h0_rd,
    input logic [NW-1:0]          h1_vld,
    input logic [NW-1:0]          h1_indep,
    input logic [NW-1:0][LW-1:0]  h1_lat,
    input logic                   s0_vld,
    input logic [WW-1:0]          s0_warp,
    input logic                   s1_vld,
    input logic [WW-1:0]          s1_warp
);
    logic [LW-1:0] chk_stall;
    logic [RW-1:0] chk_dst;
    logic          chk_rd_hit_en;
    logic [RW-1:0] chk_rd;

    // Stall value seen at the ports and the fields of the slot-0 instruction.
    always_comb begin
        chk_stall = h0_lat[s0_warp];
        if (s1_vld && h1_lat[s0_warp] > chk_stall) chk_stall = h1_lat[s0_warp];
        chk_dst       = h0_dst[s0_warp];
        chk_rd_hit_en = h0_rd_en[s0_warp];
        chk_rd        = h0_rd[s0_warp];
    end

    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!s0_vld && !s1_vld));

    p_grant_has_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s0_vld |-> h0_vld[s0_warp]);

    p_stall_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld && chk_stall != '0) |=> !(s0_vld && s0_warp == $past(s0_warp)));

    p_pending_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld && h0_long[s0_warp]) |=>
        !(s0_vld && s0_warp == $past(s0_warp) && chk_rd_hit_en && chk_rd == $past(chk_dst)));

    p_pair_rules_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |-> (s0_vld && s1_warp == s0_warp && h1_vld[s0_warp] && h1_indep[s0_warp]));
endmodule

bind warp_issue_sched wis_checker #(.NW(NW), .LW(LW), .NR(NR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h0_vld   (h0_vld),
    .h0_lat   (h0_lat),
    .h0_long  (h0_long),
    .h0_dst   (h0_dst),
    .h0_rd_en (h0_rd_en),
    .h0_rd    (h0_rd),
    .h1_vld   (h1_vld),
    .h1_indep (h1_indep),
    .h1_lat   (h1_lat),
    .s0_vld   (s0_vld),
    .s0_warp  (s0_warp),
    .s1_vld   (s1_vld),
    .s1_warp  (s1_warp)
);

// File: tb/tb_warp_issue_sched.sv
// Bench: directed corner cases plus a random sweep on a 4-warp pool.
// A cycle model that keeps issue timestamps predicts every grant.
module tb_warp_issue_sched;
    localparam int NW = 4;
    localparam int LW = 4;
    localparam int NR = 8;
    localparam int WW = 2;
    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NW-1:0]         h0_vld, h0_long, h0_dp, h0_rd_en;
    logic [NW-1:0][LW-1:0] h0_lat, h1_lat;
    logic [NW-1:0][RW-1:0] h0_dst, h0_rd, h1_dst, h1_rd;
    logic [NW-1:0]         h1_vld, h1_indep, h1_long, h1_dp, h1_rd_en;
    logic                  wb_vld;
    logic [WW-1:0]         wb_warp;
    logic [RW-1:0]         wb_reg;
    logic                  s0_vld, s0_dp, s1_vld, s1_dp;
    logic [WW-1:0]         s0_warp, s1_warp;

    warp_issue_sched #(.NW(NW), .LW(LW), .NR(NR)) dut (.*);

    int n_vec = 0, n_bad = 0;
    bit finished = 0;
    int m_cnt[NW];
    bit m_sb[NW][NR];
    int m_ts[NW];
    int m_time;
    bit a_s0v, a_s1v, a_s0d, a_s1d;
    int a_s0w;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic clr_in();
        h0_vld = '0; h0_lat = '0; h0_long = '0; h0_dp = '0; h0_dst = '0;
        h0_rd_en = '0; h0_rd = '0; h1_vld = '0; h1_indep = '0; h1_lat = '0;
        h1_long = '0; h1_dp = '0; h1_dst = '0; h1_rd_en = '0; h1_rd = '0;
        wb_vld = 0; wb_warp = '0; wb_reg = '0;
    endtask

    task automatic model_reset();
        for (int w = 0; w < NW; w++) begin
            m_cnt[w] = 0; m_ts[w] = 0;
            for (int r = 0; r < NR; r++) m_sb[w][r] = 0;
        end
        m_time = 0;
    endtask

    // Reset the design for three cycles; R1 outputs must stay quiet meanwhile.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clr_in();
        h0_vld = '1; h1_vld = '1; h1_indep = '1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!s0_vld && !s1_vld, "R1 quiet in reset", int'(s0_vld), 0);
            @(negedge clk);
        end
        rst_n = 1;
        clr_in();
        model_reset();
    endtask

    // One cycle: compare with the model, advance the model, wait for the next negedge.
    task automatic step(input string tag);
        int best;
        bit e0, e1;
        #1;
        best = -1;
        for (int w = 0; w < NW; w++) begin
            bit el;
            el = h0_vld[w] && m_cnt[w] == 0 && !(h0_rd_en[w] && m_sb[w][h0_rd[w]]);
            if (el && (best < 0 || m_ts[w] < m_ts[best])) best = w;
        end
        e0 = best >= 0;
        e1 = e0 && h1_vld[best] && h1_indep[best] && !(h1_rd_en[best] && m_sb[best][h1_rd[best]]);
        a_s0v = s0_vld; a_s1v = s1_vld; a_s0d = s0_dp; a_s1d = s1_dp; a_s0w = int'(s0_warp);
        chk(s0_vld == e0, {tag, " s0_vld"}, int'(s0_vld), int'(e0));
        if (e0 && s0_vld) begin
            chk(int'(s0_warp) == best, {tag, " s0_warp"}, int'(s0_warp), best);
            chk(s0_dp == h0_dp[best], {tag, " R8 s0_dp"}, int'(s0_dp), int'(h0_dp[best]));
        end
        chk(s1_vld == e1, {tag, " R6 s1_vld"}, int'(s1_vld), int'(e1));
        if (e1 && s1_vld) begin
            chk(int'(s1_warp) == best, {tag, " R6 s1_warp"}, int'(s1_warp), best);
            chk(s1_dp == h1_dp[best], {tag, " R8 s1_dp"}, int'(s1_dp), int'(h1_dp[best]));
        end
        for (int w = 0; w < NW; w++)
            if (w != best && m_cnt[w] > 0) m_cnt[w]--;
        if (wb_vld) m_sb[wb_warp][wb_reg] = 0;
        if (e0) begin
            m_cnt[best] = e1 ? ((h0_lat[best] > h1_lat[best]) ? int'(h0_lat[best]) : int'(h1_lat[best]))
                             : int'(h0_lat[best]);
            m_time++;
            m_ts[best] = m_time;
            if (h0_long[best]) m_sb[best][h0_dst[best]] = 1;
            if (e1 && h1_long[best]) m_sb[best][h1_dst[best]] = 1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        clr_in();
        model_reset();
        do_reset();

        // R2: all warps always ready, latency 0 -> rotation by index.
        h0_vld = '1;
        for (int k = 0; k < 6; k++) begin
            step("R2");
            chk(a_s0v && a_s0w == k % NW, "R2 oldest-first order", a_s0w, k % NW);
        end

        // R3: latency 3, then 15, then 0 (back to back).
        do_reset();
        h0_vld[2] = 1; h0_lat[2] = 3;
        step("R3");
        chk(a_s0v && a_s0w == 2, "R3 first issue", a_s0w, 2);
        for (int k = 0; k < 3; k++) begin
            step("R3");
            chk(!a_s0v, "R3 masked during stall 3", int'(a_s0v), 0);
        end
        h0_lat[2] = 15;
        step("R3");
        chk(a_s0v, "R3 issue at cycle L+1", int'(a_s0v), 1);
        for (int k = 0; k < 15; k++) begin
            step("R3");
            chk(!a_s0v, "R3 masked during stall 15", int'(a_s0v), 0);
        end
        h0_lat[2] = 0;
        step("R3");
        chk(a_s0v, "R3 issue after stall 15", int'(a_s0v), 1);
        step("R3");
        chk(a_s0v, "R3 back to back with L=0", int'(a_s0v), 1);

        // R4/R5: scoreboard blocks only its own warp; writeback frees next cycle.
        do_reset();
        h0_vld[1] = 1; h0_long[1] = 1; h0_dst[1] = 5;
        step("R4");
        chk(a_s0v && a_s0w == 1, "R4 load issues", a_s0w, 1);
        h0_long[1] = 0; h0_rd_en[1] = 1; h0_rd[1] = 5;
        h0_vld[3] = 1; h0_rd_en[3] = 1; h0_rd[3] = 5;
        step("R4");
        chk(a_s0v && a_s0w == 3, "R4 other warp unaffected", a_s0w, 3);
        h0_vld[3] = 0;
        for (int k = 0; k < 2; k++) begin
            step("R4");
            chk(!a_s0v, "R4 pending source blocks", int'(a_s0v), 0);
        end
        wb_vld = 1; wb_warp = 1; wb_reg = 5;
        step("R5");
        chk(!a_s0v, "R5 not ready in writeback cycle", int'(a_s0v), 0);
        wb_vld = 0;
        step("R5");
        chk(a_s0v && a_s0w == 1, "R5 ready after writeback", a_s0w, 1);

        // R7: set and clear of one entry in the same cycle -> pending.
        do_reset();
        h0_vld[0] = 1; h0_long[0] = 1; h0_dst[0] = 2;
        wb_vld = 1; wb_warp = 0; wb_reg = 2;
        step("R7");
        chk(a_s0v && a_s0w == 0, "R7 load issues", a_s0w, 0);
        wb_vld = 0; h0_long[0] = 0; h0_rd_en[0] = 1; h0_rd[0] = 2;
        step("R7");
        chk(!a_s0v, "R7 set wins over clear", int'(a_s0v), 0);
        wb_vld = 1;
        step("R7");
        wb_vld = 0;
        step("R7");
        chk(a_s0v, "R7 freed by later writeback", int'(a_s0v), 1);

        // R6/R8/R9: double-precision pair, stall = max, pairing refusals.
        do_reset();
        h0_vld[3] = 1; h0_dp[3] = 1; h0_lat[3] = 1;
        h1_vld[3] = 1; h1_indep[3] = 1; h1_dp[3] = 1; h1_lat[3] = 4;
        step("R8");
        chk(a_s0v && a_s1v && a_s0d && a_s1d, "R8 double-precision pair", int'(a_s1v), 1);
        for (int k = 0; k < 4; k++) begin
            step("R9");
            chk(!a_s0v, "R9 pair stall is max latency", int'(a_s0v), 0);
        end
        h1_indep[3] = 0; h0_long[3] = 1; h0_dst[3] = 6;
        step("R6");
        chk(a_s0v && !a_s1v, "R6 dependent second stays", int'(a_s1v), 0);
        step("R9");
        chk(!a_s0v, "R9 single stall uses slot-0 latency", int'(a_s0v), 0);
        h0_long[3] = 0; h1_indep[3] = 1; h1_rd_en[3] = 1; h1_rd[3] = 6;
        step("R6");
        chk(a_s0v && !a_s1v, "R6 pending source blocks slot 1", int'(a_s1v), 0);

        // Random sweep in three densities; every cycle compared with the model.
        do_reset();
        for (int ph = 0; ph < 3; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                for (int w = 0; w < NW; w++) begin
                    h0_vld[w]   = ($urandom % 4) < (ph == 1 ? 1 : 3);
                    h0_lat[w]   = ($urandom % 8 == 0) ? LW'($urandom % 16) : LW'($urandom % 3);
                    h0_long[w]  = ($urandom % (ph == 2 ? 2 : 5)) == 0;
                    h0_dp[w]    = $urandom % 2;
                    h0_dst[w]   = RW'($urandom % NR);
                    h0_rd_en[w] = $urandom % 2;
                    h0_rd[w]    = RW'($urandom % NR);
                    h1_vld[w]   = $urandom % 2;
                    h1_indep[w] = $urandom % 2;
                    h1_lat[w]   = LW'($urandom % 4);
                    h1_long[w]  = ($urandom % 4) == 0;
                    h1_dp[w]    = $urandom % 2;
                    h1_dst[w]   = RW'($urandom % NR);
                    h1_rd_en[w] = $urandom % 2;
                    h1_rd[w]    = RW'($urandom % NR);
                end
                wb_vld  = ($urandom % 3) != 0;
                wb_warp = WW'($urandom % NW);
                wb_reg  = RW'($urandom % NR);
                step("R2 R3 R4 R5 R7 R9 random");
            end
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule